// File: doc/BRIEF.md
# Indexed Colour Palette RAM

This block is a 256-entry colour lookup table. Each entry holds a red, a green and a blue component of six bits. A processor reaches the table through four byte-wide registers on a two-bit register address. These are a write-entry pointer, a read-entry pointer, a serial colour data port and a pixel mask.

Data port accesses are serial. After a pointer is loaded, the first data access touches red, the second touches green and the third touches blue. The pointer then moves on to the next entry. The write side and the read side each have their own pointer and their own colour-phase counter.

The display side presents an 8-bit pixel value every cycle. The block ANDs that value with the mask and returns the selected entry's RGB triple one clock later. This lookup runs at the same time as processor accesses.

Top module: `paletteRam`

## Requirements
- R1: After a synchronous reset, register 0 (write pointer) and register 3 (read pointer) both read 0x00. Register 2 (mask) reads 0xFF. The first data write goes to red of entry 0.
- R2: Writing register 0 loads the write pointer with the written byte and returns the write phase to red. Reading register 0 returns the pointer.
- R3: Each write to register 1 (data) stores bits 5..0 into the current component in the order red, green, blue. After blue, the write pointer advances by one.
- R4: From write pointer 0x00, 768 data writes leave the write pointer wrapped to 0x00.
- R5: Writing register 3 loads the read pointer and returns the read phase to red. Each data-register read returns red, then green, then blue of that entry, then advances the read pointer. The read data is valid combinationally in the cycle of the read.
- R6: A component read returns its six stored bits on bits 5..0 and zeros on bits 7..6, whatever the upper bits of the written byte were.
- R7: Writing register 2 sets the pixel mask. The entry looked up is pixel AND mask, so 0xFF leaves the pixel unchanged.
- R8: Loading the read pointer changes neither the write pointer nor the write phase. Loading the write pointer changes neither the read pointer nor the read phase.
- R9: The RGB outputs show the entry for the pixel value and mask present at a clock edge, starting from that edge.
- R10: When a data write and a pixel lookup hit the same entry at one edge, the lookup returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpuWrEn | input | 1 | Register write strobe |
| cpuRdEn | input | 1 | Register read strobe; it advances the read phase only on register 1 |
| cpuAddr | input | 2 | Register select: 0 write pointer, 1 data, 2 mask, 3 read pointer |
| cpuWdata | input | 8 | Write data |
| cpuRdata | output | 8 | Read data for the selected register (combinational) |
| pixIdx | input | 8 | Pixel value to look up |
| pixRed | output | 6 | Red of the looked-up entry |
| pixGreen | output | 6 | Green of the looked-up entry |
| pixBlue | output | 6 | Blue of the looked-up entry |

## Verification
Register and data-port reads are combinational. The bench therefore samples `cpuRdata` in the same cycle as the read strobe, shortly after driving it and well before the edge that advances the read phase.

Pointer and mask updates become visible on the cycle after the write. Pixel results appear one edge after the pixel value is applied. The bench drives inputs on falling edges and reads the RGB outputs at the next falling edge.

The same-entry collision case is checked over two successive falling edges: the old value is expected first, then the new one.

// File: rtl/palPkg.sv
package palPkg;
  localparam int IDX_W  = 8;
  localparam int COMP_W = 6;
  localparam int BUS_W  = 8;

  typedef enum logic [1:0] {
    REG_WPTR = 2'd0,
    REG_DATA = 2'd1,
    REG_MASK = 2'd2,
    REG_RPTR = 2'd3
  } palReg_e;

  typedef struct packed {
    logic             memWr;
    logic [1:0]       wrPhase;
    logic [IDX_W-1:0] wrIdx;
    logic [1:0]       rdPhase;
    logic [IDX_W-1:0] rdIdx;
    logic             maskWr;
  } palStrobe_t;
endpackage

// File: rtl/palControl.sv
module palControl
  import palPkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cpuWrEn,
  input  logic             cpuRdEn,
  input  logic [1:0]       cpuAddr,
  input  logic [BUS_W-1:0] cpuWdata,
  output palStrobe_t       stb
);
  logic [IDX_W-1:0] wrIdx, rdIdx;
  logic [1:0]       wrPh, rdPh;
  logic             wrPtrLoad, rdPtrLoad, dataWr, dataRd;

  assign wrPtrLoad = cpuWrEn && (cpuAddr == REG_WPTR);
  assign rdPtrLoad = cpuWrEn && (cpuAddr == REG_RPTR);
  assign dataWr    = cpuWrEn && (cpuAddr == REG_DATA);
  assign dataRd    = cpuRdEn && (cpuAddr == REG_DATA);

  // write side: pointer plus modulo-3 colour phase
  always_ff @(posedge clk) begin
    if (rst) begin
      wrIdx <= '0;
      wrPh  <= 2'd0;
    end else if (wrPtrLoad) begin
      wrIdx <= cpuWdata[IDX_W-1:0];
      wrPh  <= 2'd0;
    end else if (dataWr) begin
      if (wrPh == 2'd2) begin
        wrPh  <= 2'd0;
        wrIdx <= wrIdx + 1'b1;
      end else begin
        wrPh <= wrPh + 2'd1;
      end
    end
  end

  // read side: independent pointer and phase
  always_ff @(posedge clk) begin
    if (rst) begin
      rdIdx <= '0;
      rdPh  <= 2'd0;
    end else if (rdPtrLoad) begin
      rdIdx <= cpuWdata[IDX_W-1:0];
      rdPh  <= 2'd0;
    end else if (dataRd) begin
      if (rdPh == 2'd2) begin
        rdPh  <= 2'd0;
        rdIdx <= rdIdx + 1'b1;
      end else begin
        rdPh <= rdPh + 2'd1;
      end
    end
  end

  always_comb begin
    stb.memWr   = dataWr;
    stb.wrPhase = wrPh;
    stb.wrIdx   = wrIdx;
    stb.rdPhase = rdPh;
    stb.rdIdx   = rdIdx;
    stb.maskWr  = cpuWrEn && (cpuAddr == REG_MASK);
  end
endmodule

// File: rtl/palDatapath.sv
module palDatapath
  import palPkg::*;
#(
  parameter int ENTRIES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  palStrobe_t        stb,
  input  logic [1:0]        cpuAddr,
  input  logic [BUS_W-1:0]  cpuWdata,
  output logic [BUS_W-1:0]  cpuRdata,
  input  logic [IDX_W-1:0]  pixIdx,
  output logic [COMP_W-1:0] pixRed,
  output logic [COMP_W-1:0] pixGreen,
  output logic [COMP_W-1:0] pixBlue
);
  localparam int NCOMP = 3;

  logic [IDX_W-1:0]  maskQ;
  logic [IDX_W-1:0]  lookIdx;
  logic [COMP_W-1:0] rdComp  [NCOMP];
  logic [COMP_W-1:0] pixComp [NCOMP];
  logic [COMP_W-1:0] selComp;

  always_ff @(posedge clk) begin
    if (rst)             maskQ <= '1;
    else if (stb.maskWr) maskQ <= cpuWdata[IDX_W-1:0];
  end

  assign lookIdx = pixIdx & maskQ;

  // one storage bank per colour component
  for (genvar c = 0; c < NCOMP; c++) begin : gBank
    logic [COMP_W-1:0] bank [ENTRIES];

    always_ff @(posedge clk) begin
      if (stb.memWr && (stb.wrPhase == 2'(c)))
        bank[stb.wrIdx] <= cpuWdata[COMP_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (rst) pixComp[c] <= '0;
      else     pixComp[c] <= bank[lookIdx];
    end

    assign rdComp[c] = bank[stb.rdIdx];
  end

  always_comb begin
    case (stb.rdPhase)
      2'd0:    selComp = rdComp[0];
      2'd1:    selComp = rdComp[1];
      2'd2:    selComp = rdComp[2];
      default: selComp = '0;
    endcase
  end

  always_comb begin
    case (cpuAddr)
      REG_WPTR: cpuRdata = BUS_W'(stb.wrIdx);
      REG_DATA: cpuRdata = BUS_W'(selComp);
      REG_MASK: cpuRdata = BUS_W'(maskQ);
      default:  cpuRdata = BUS_W'(stb.rdIdx);
    endcase
  end

  assign pixRed   = pixComp[0];
  assign pixGreen = pixComp[1];
  assign pixBlue  = pixComp[2];
endmodule

// File: rtl/paletteRam.sv
module paletteRam
  import palPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cpuWrEn,
  input  logic              cpuRdEn,
  input  logic [1:0]        cpuAddr,
  input  logic [BUS_W-1:0]  cpuWdata,
  output logic [BUS_W-1:0]  cpuRdata,
  input  logic [IDX_W-1:0]  pixIdx,
  output logic [COMP_W-1:0] pixRed,
  output logic [COMP_W-1:0] pixGreen,
  output logic [COMP_W-1:0] pixBlue
);
  palStrobe_t       stb;
  logic [IDX_W-1:0] curWrIdx, curRdIdx;
  logic [1:0]       curWrPhase, curRdPhase;

  palControl uCtl (
    .clk(clk), .rst(rst), .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .stb(stb)
  );

  palDatapath #(.ENTRIES(1 << IDX_W)) uDp (
    .clk(clk), .rst(rst), .stb(stb), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .pixIdx(pixIdx),
    .pixRed(pixRed), .pixGreen(pixGreen), .pixBlue(pixBlue)
  );

  assign curWrIdx   = stb.wrIdx;
  assign curRdIdx   = stb.rdIdx;
  assign curWrPhase = stb.wrPhase;
  assign curRdPhase = stb.rdPhase;
endmodule

// File: rtl/palChecker.sv
module palChecker (
  input logic       clk,
  input logic       rst,
  input logic       cpuWrEn,
  input logic       cpuRdEn,
  input logic [1:0] cpuAddr,
  input logic [7:0] cpuWdata,
  input logic [7:0] cpuRdata,
  input logic [7:0] curWrIdx,
  input logic [7:0] curRdIdx,
  input logic [1:0] curWrPhase,
  input logic [1:0] curRdPhase
);
  // R2
  wptr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cpuWrEn && cpuAddr == 2'd0) |=> (curWrIdx == $past(cpuWdata) && curWrPhase == 2'd0));

  // R3
  wphase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cpuWrEn && cpuAddr == 2'd1 && curWrPhase == 2'd2)
      |=> (curWrIdx == $past(curWrIdx) + 8'd1 && curWrPhase == 2'd0));

  // R5
  rptr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cpuWrEn && cpuAddr == 2'd3) |=> (curRdIdx == $past(cpuWdata) && curRdPhase == 2'd0));

  // R6
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cpuRdEn && cpuAddr == 2'd1) |-> (cpuRdata[7:6] == 2'b00));

  // R8
  wside_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (cpuWrEn && cpuAddr == 2'd3) |=> ($stable(curWrIdx) && $stable(curWrPhase)));

  // R8
  rside_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (cpuWrEn && cpuAddr == 2'd0 && !cpuRdEn) |=> ($stable(curRdIdx) && $stable(curRdPhase)));
endmodule

bind paletteRam palChecker chk (
  .clk(clk), .rst(rst), .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn), .cpuAddr(cpuAddr),
  .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .curWrIdx(curWrIdx), .curRdIdx(curRdIdx),
  .curWrPhase(curWrPhase), .curRdPhase(curRdPhase)
);

// File: tb/tb_paletteRam.sv
module tb_paletteRam;
  logic       clk = 1'b0;
  logic       rst;
  logic       cpuWrEn, cpuRdEn;
  logic [1:0] cpuAddr;
  logic [7:0] cpuWdata, cpuRdata, pixIdx;
  logic [5:0] pixRed, pixGreen, pixBlue;

  int total = 0;
  int bad   = 0;
  logic [5:0] model [256][3];
  logic [5:0] oldRed;
  logic [7:0] rv;

  // {pixel, mask} probes
  localparam logic [15:0] PROBES [8] = '{
    16'h00FF, 16'h7FFF, 16'hFFFF, 16'hA50F,
    16'h3CF0, 16'hFF00, 16'h8181, 16'h5AAA
  };

  always #2.5 clk = ~clk;

  paletteRam dut (
    .clk(clk), .rst(rst), .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .pixIdx(pixIdx),
    .pixRed(pixRed), .pixGreen(pixGreen), .pixBlue(pixBlue)
  );

  function automatic logic [5:0] colourOf(input int i, input int c);
    case (c)
      0:       return 6'(i);
      1:       return 6'(i >> 2) ^ 6'h15;
      default: return 6'(i * 3 + 7);
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // tasks start just after a falling edge and return at the next one
  task automatic cpuWrite(input logic [1:0] a, input logic [7:0] d);
    cpuWrEn = 1'b1; cpuAddr = a; cpuWdata = d;
    @(negedge clk);
    cpuWrEn = 1'b0;
  endtask

  task automatic cpuRead(input logic [1:0] a, output logic [7:0] d);
    cpuRdEn = 1'b1; cpuAddr = a;
    #1 d = cpuRdata;
    @(negedge clk);
    cpuRdEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; cpuWrEn = 0; cpuRdEn = 0; cpuAddr = 0; cpuWdata = 0; pixIdx = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    cpuRead(2'd0, rv); check(rv == 8'h00, "R1 write pointer", rv, 0);
    cpuRead(2'd3, rv); check(rv == 8'h00, "R1 read pointer", rv, 0);
    cpuRead(2'd2, rv); check(rv == 8'hFF, "R1 mask", rv, 8'hFF);

    // R3 fill whole table from entry 0 (upper bits set to probe R6)
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++) begin
        model[i][c] = colourOf(i, c);
        cpuWrite(2'd1, {2'b11, colourOf(i, c)});
      end
    // R4 pointer wrapped
    cpuRead(2'd0, rv); check(rv == 8'h00, "R4 wrap after 768 writes", rv, 0);

    // R5 R6 read the whole table back
    cpuWrite(2'd3, 8'h00);
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++) begin
        cpuRead(2'd1, rv);
        check(rv == {2'b00, model[i][c]}, "R5 R6 readback", rv, model[i][c]);
      end
    cpuRead(2'd3, rv); check(rv == 8'h00, "R5 read pointer wrap", rv, 0);

    // R2 reloading the write pointer restarts at red
    cpuWrite(2'd0, 8'h05);
    cpuWrite(2'd1, 8'h01); model[5][0] = 6'h01;
    cpuWrite(2'd1, 8'h02); model[5][1] = 6'h02;
    cpuWrite(2'd0, 8'h09);
    cpuRead(2'd0, rv); check(rv == 8'h09, "R2 write pointer load", rv, 9);
    cpuWrite(2'd1, 8'h2A); model[9][0] = 6'h2A;
    cpuWrite(2'd1, 8'h15); model[9][1] = 6'h15;
    cpuWrite(2'd1, 8'h3F); model[9][2] = 6'h3F;
    cpuRead(2'd0, rv); check(rv == 8'h0A, "R3 advance after blue", rv, 8'h0A);
    cpuWrite(2'd3, 8'h05);
    for (int c = 0; c < 3; c++) begin
      cpuRead(2'd1, rv);
      check(rv == {2'b00, model[5][c]}, "R2 partial entry 5", rv, model[5][c]);
    end
    cpuWrite(2'd3, 8'h09);
    for (int c = 0; c < 3; c++) begin
      cpuRead(2'd1, rv);
      check(rv == {2'b00, model[9][c]}, "R2 entry 9 starts at red", rv, model[9][c]);
    end

    // R8 side independence, interleaved mid-entry
    cpuWrite(2'd0, 8'd20);
    cpuWrite(2'd1, 8'h11); model[20][0] = 6'h11;
    cpuWrite(2'd3, 8'd40);
    cpuRead(2'd0, rv); check(rv == 8'd20, "R8 write pointer kept", rv, 20);
    cpuRead(2'd1, rv); check(rv == {2'b00, model[40][0]}, "R8 read red", rv, model[40][0]);
    cpuWrite(2'd0, 8'd20);
    cpuRead(2'd3, rv); check(rv == 8'd40, "R8 read pointer kept", rv, 40);
    cpuRead(2'd1, rv); check(rv == {2'b00, model[40][1]}, "R8 read phase kept", rv, model[40][1]);
    cpuWrite(2'd3, 8'd20);
    cpuRead(2'd1, rv); check(rv == {2'b00, model[20][0]}, "R8 write landed", rv, model[20][0]);

    // R7 R9 pixel lookups through the mask
    foreach (PROBES[k]) begin
      logic [7:0] e;
      cpuWrite(2'd2, PROBES[k][7:0]);
      pixIdx = PROBES[k][15:8];
      e = PROBES[k][15:8] & PROBES[k][7:0];
      @(negedge clk);
      check({pixRed, pixGreen, pixBlue} == {model[e][0], model[e][1], model[e][2]},
            "R7 R9 masked lookup", {pixRed, pixGreen, pixBlue},
            {model[e][0], model[e][1], model[e][2]});
    end

    // R9 one-edge latency: change pixel, result follows one edge later
    cpuWrite(2'd2, 8'hFF);
    pixIdx = 8'd3;
    @(negedge clk);
    pixIdx = 8'd200;
    #1 check(pixBlue == model[3][2], "R9 output held until edge", pixBlue, model[3][2]);
    @(negedge clk);
    check(pixBlue == model[200][2], "R9 output after one edge", pixBlue, model[200][2]);

    // R10 collision returns the old value
    cpuWrite(2'd0, 8'd7);
    pixIdx = 8'd7;
    oldRed = model[7][0];
    cpuWrite(2'd1, 8'h3C); model[7][0] = 6'h3C;
    check(pixRed == oldRed, "R10 old value on collision", pixRed, oldRed);
    @(negedge clk);
    check(pixRed == 6'h3C, "R10 new value next cycle", pixRed, 6'h3C);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule